// File: doc/BRIEF.md
# Logic Self-Test Partition Controller

This block sequences the scan-based self-test of one logic partition. Once started, it applies a programmed number of test patterns. Each pattern is a fixed run of 50 shift steps followed by 25 capture steps. A step happens once every `shiftDiv + 1` clock cycles, so the divider sets the effective scan rate relative to the system clock. Captured response data is folded into a 64-bit multiple-input signature register (MISR). A small pseudo-random generator stands in for the real scan chains.

When the last pattern finishes, the block compares the accumulated signature with an expected value supplied as a low and a high 32-bit word. It then raises `done` and, on a match, `pass`. A mismatch raises exactly one of two fault outputs, chosen by a fault-map input. One marks the failure as recoverable. The other asks the system for a reset. An abort request during a run stops the test at once and freezes the partial signature and counters so that software can inspect them.

Top module: `logic_selftest_part`

## Requirements
- R1: While `rstN` is low and after its release, `busy`, `done`, `pass`, `faultRec`, `resetReq` and `aborted` are 0, and `signature`, `patCount`, `shiftCount` and `capCount` are 0.
- R2: A `start` pulse seen while idle clears the signature, the counters and all result flags, and captures `patStop` and `shiftDiv`. While the block is busy, `start` and changes to `patStop` or `shiftDiv` have no effect on the run.
- R3: Every pattern is exactly 50 shift steps followed by 25 capture steps. `capCount` is non-zero only once `shiftCount` reads 50. At the end of a full run the block reads `patCount` = `patStop`, `shiftCount` = 50 and `capCount` = 25.
- R4: One step happens every `shiftDiv + 1` clock cycles. `done` reads 1 right after rising edge number 75·P·(D+1)+1 that follows the edge that sampled `start`, where P = `patStop` and D = `shiftDiv`.
- R5: The stub source loads the seed 64'h0123456789ABCDEF at start and advances on every step as s' = {s[62:0],0} ^ (s[63] ? 64'h1B : 0). On each capture step the MISR becomes m' = {m[62:0],0} ^ (m[63] ? 64'h1B : 0) ^ s, where s is the stub value before that step. The MISR is 0 at start.
- R6: `pass` is set only when `signature` equals {`expHi`,`expLo`} in all 64 bits. A single differing bit in either word gives `pass` = 0.
- R7: On a mismatch, `faultMapUnrec` = 0 sets `faultRec`, and `faultMapUnrec` = 1 sets `resetReq`. Never both are set, and neither is set on a pass.
- R8: `done`, `pass` and the fault flags hold their values, with `signature` unchanged, until the next accepted `start`. `done` and `busy` are never 1 together.
- R9: `abortReq` during a run ends it on the next edge with `done` = 1, `aborted` = 1, `pass` = 0, `busy` = 0 and no fault flag. `signature` and the counters keep the values they held at that point, with no step taken on the aborting edge.
- R10: With `patStop` = 0 no step is taken. `done` rises one edge after start, and the all-zero signature is compared against the expected value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| abortReq | input | 1 | Abort the run in progress, keeping partial results |
| patStop | input | PAT_W | Number of patterns to apply |
| shiftDiv | input | DIV_W | Step rate divider, one step per shiftDiv+1 cycles |
| expLo | input | 32 | Expected signature bits 31:0 |
| expHi | input | 32 | Expected signature bits 63:32 |
| faultMapUnrec | input | 1 | 1: failure requests reset; 0: failure is recoverable |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished or aborted |
| pass | output | 1 | Signature matched |
| faultRec | output | 1 | Recoverable failure flag |
| resetReq | output | 1 | Unrecoverable failure, reset requested |
| aborted | output | 1 | Last run was aborted |
| signature | output | 64 | MISR contents |
| patCount | output | PAT_W | Patterns completed |
| shiftCount | output | 6 | Shift steps in current pattern |
| capCount | output | 5 | Capture steps in current pattern |

## Verification
The bench times `done` against the step-rate formula with the divider at 0 and at 3. An off-by-one in the divider or in the pattern boundary would move `done` by whole steps or whole patterns. It flips one bit in each expected word in turn: a compare that checks only one half, or uses reduced equality, would wrongly pass one of these. It aborts a run ten captures into the first pattern and compares the frozen signature and counters with a model. A design that clears them or takes one more step would differ. It also restarts mid-run with changed settings, and runs a zero-pattern test: a block that re-latched its settings or stepped once anyway would show different counts or timing.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int SIG_W         = 64;
  localparam int WORD_W        = 32;
  localparam int SHIFT_N       = 50;
  localparam int CAP_N         = 25;
  localparam int SHIFT_W       = $clog2(SHIFT_N + 1);
  localparam int CAP_W         = $clog2(CAP_N + 1);
  localparam logic [SIG_W-1:0] FB_POLY = 64'h0000_0000_0000_001B;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} lstState_t;

  typedef struct packed {
    logic clear;
    logic shiftStep;
    logic capStep;
    logic compare;
    logic abort;
  } lstStrobe_t;

  function automatic logic [SIG_W-1:0] lfsrAdvance(input logic [SIG_W-1:0] s);
    return {s[SIG_W-2:0], 1'b0} ^ (s[SIG_W-1] ? FB_POLY : '0);
  endfunction

  function automatic logic [SIG_W-1:0] misrAbsorb(input logic [SIG_W-1:0] m,
                                                  input logic [SIG_W-1:0] d);
    return lfsrAdvance(m) ^ d;
  endfunction
endpackage

// File: rtl/lst_seq_ctrl.sv
module lst_seq_ctrl
  import lst_pkg::*;
#(
  parameter int PAT_W = 16,
  parameter int DIV_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               abortReq,
  input  logic [PAT_W-1:0]   patStop,
  input  logic [DIV_W-1:0]   shiftDiv,
  output lstStrobe_t         strb,
  output logic               busy,
  output logic [PAT_W-1:0]   patCount,
  output logic [SHIFT_W-1:0] shiftCount,
  output logic [CAP_W-1:0]   capCount
);
  lstState_t          state;
  logic [PAT_W-1:0]   patStopQ;
  logic [DIV_W-1:0]   divQ;
  logic [DIV_W-1:0]   divCnt;
  logic               inShift;
  logic               tick;
  logic               stepEn;
  logic               lastShift;
  logic               lastCap;
  logic               lastPat;

  assign tick      = (divCnt == divQ);
  assign stepEn    = (state == ST_RUN) && !abortReq && tick;
  assign lastShift = (shiftCount == SHIFT_W'(SHIFT_N - 1));
  assign lastCap   = (capCount == CAP_W'(CAP_N - 1));
  assign lastPat   = ((patCount + PAT_W'(1)) == patStopQ);

  always_comb begin
    strb           = '0;
    strb.clear     = (state == ST_IDLE) && start;
    strb.shiftStep = stepEn && inShift;
    strb.capStep   = stepEn && !inShift;
    strb.compare   = (state == ST_FINISH);
    strb.abort     = (state == ST_RUN) && abortReq;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      patStopQ   <= '0;
      divQ       <= '0;
      divCnt     <= '0;
      inShift    <= 1'b1;
      patCount   <= '0;
      shiftCount <= '0;
      capCount   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            patStopQ   <= patStop;
            divQ       <= shiftDiv;
            divCnt     <= '0;
            inShift    <= 1'b1;
            patCount   <= '0;
            shiftCount <= '0;
            capCount   <= '0;
            state      <= (patStop == '0) ? ST_FINISH : ST_RUN;
          end
        end
        ST_RUN: begin
          if (abortReq) begin
            state <= ST_IDLE;
          end else if (tick) begin
            divCnt <= '0;
            if (inShift) begin
              shiftCount <= shiftCount + SHIFT_W'(1);
              if (lastShift) inShift <= 1'b0;
            end else begin
              capCount <= capCount + CAP_W'(1);
              if (lastCap) begin
                patCount <= patCount + PAT_W'(1);
                if (lastPat) begin
                  state <= ST_FINISH;
                end else begin
                  shiftCount <= '0;
                  capCount   <= '0;
                  inShift    <= 1'b1;
                end
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lst_sig_path.sv
module lst_sig_path
  import lst_pkg::*;
#(
  parameter logic [SIG_W-1:0] STUB_SEED = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  lstStrobe_t        strb,
  input  logic [WORD_W-1:0] expLo,
  input  logic [WORD_W-1:0] expHi,
  input  logic              faultMapUnrec,
  output logic [SIG_W-1:0]  signature,
  output logic              done,
  output logic              pass,
  output logic              faultRec,
  output logic              resetReq,
  output logic              aborted
);
  localparam int WORDS = SIG_W / WORD_W;

  logic [SIG_W-1:0]  stubQ;
  logic [SIG_W-1:0]  expFull;
  logic [WORDS-1:0]  wordEq;
  logic              sigMatch;

  assign expFull = {expHi, expLo};

  for (genvar w = 0; w < WORDS; w++) begin : g_cmp
    assign wordEq[w] = (signature[w*WORD_W +: WORD_W] == expFull[w*WORD_W +: WORD_W]);
  end
  assign sigMatch = &wordEq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stubQ     <= STUB_SEED;
      signature <= '0;
    end else if (strb.clear) begin
      stubQ     <= STUB_SEED;
      signature <= '0;
    end else begin
      if (strb.shiftStep || strb.capStep) stubQ <= lfsrAdvance(stubQ);
      if (strb.capStep) signature <= misrAbsorb(signature, stubQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      pass     <= 1'b0;
      faultRec <= 1'b0;
      resetReq <= 1'b0;
      aborted  <= 1'b0;
    end else if (strb.clear) begin
      done     <= 1'b0;
      pass     <= 1'b0;
      faultRec <= 1'b0;
      resetReq <= 1'b0;
      aborted  <= 1'b0;
    end else if (strb.compare) begin
      done     <= 1'b1;
      pass     <= sigMatch;
      faultRec <= !sigMatch && !faultMapUnrec;
      resetReq <= !sigMatch && faultMapUnrec;
    end else if (strb.abort) begin
      done     <= 1'b1;
      pass     <= 1'b0;
      aborted  <= 1'b1;
    end
  end
endmodule

// File: rtl/logic_selftest_part.sv
module logic_selftest_part
  import lst_pkg::*;
#(
  parameter int PAT_W = 16,
  parameter int DIV_W = 4,
  parameter logic [63:0] STUB_SEED = 64'h0123_4567_89AB_CDEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               abortReq,
  input  logic [PAT_W-1:0]   patStop,
  input  logic [DIV_W-1:0]   shiftDiv,
  input  logic [31:0]        expLo,
  input  logic [31:0]        expHi,
  input  logic               faultMapUnrec,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic               faultRec,
  output logic               resetReq,
  output logic               aborted,
  output logic [63:0]        signature,
  output logic [PAT_W-1:0]   patCount,
  output logic [5:0]         shiftCount,
  output logic [4:0]         capCount
);
  lstStrobe_t strb;

  lst_seq_ctrl #(.PAT_W(PAT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .abortReq(abortReq),
    .patStop(patStop), .shiftDiv(shiftDiv), .strb(strb), .busy(busy),
    .patCount(patCount), .shiftCount(shiftCount), .capCount(capCount)
  );

  lst_sig_path #(.STUB_SEED(STUB_SEED)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .expLo(expLo), .expHi(expHi),
    .faultMapUnrec(faultMapUnrec), .signature(signature), .done(done),
    .pass(pass), .faultRec(faultRec), .resetReq(resetReq), .aborted(aborted)
  );
endmodule

// File: rtl/logic_selftest_chk.sv
module logic_selftest_chk #(
  parameter int PAT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic             faultRec,
  input logic             resetReq,
  input logic             aborted,
  input logic [63:0]      signature,
  input logic [PAT_W-1:0] patCount,
  input logic [5:0]       shiftCount,
  input logic [4:0]       capCount
);
  // R3
  shift_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftCount <= 6'd50) && (capCount <= 5'd25));

  // R3
  cap_after_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capCount != 5'd0) |-> (shiftCount == 6'd50));

  // R7
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({faultRec, resetReq}));

  // R7
  fault_only_on_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultRec || resetReq) |-> (done && !pass && !aborted));

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(signature));

  // R9
  abort_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    aborted |-> (done && !pass));

  // R6
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

  // R2
  count_frozen_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(patCount));
endmodule

bind logic_selftest_part logic_selftest_chk #(.PAT_W(PAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .pass(pass), .faultRec(faultRec), .resetReq(resetReq), .aborted(aborted),
  .signature(signature), .patCount(patCount), .shiftCount(shiftCount),
  .capCount(capCount)
);

// File: tb/logic_selftest_part_tb.sv
module logic_selftest_part_tb;
  localparam int PAT_W = 16;
  localparam int DIV_W = 4;
  localparam logic [63:0] SEED = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] POLY = 64'h1B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic abortReq = 1'b0;
  logic [PAT_W-1:0] patStop = '0;
  logic [DIV_W-1:0] shiftDiv = '0;
  logic [31:0] expLo = '0;
  logic [31:0] expHi = '0;
  logic faultMapUnrec = 1'b0;
  logic busy, done, pass, faultRec, resetReq, aborted;
  logic [63:0] signature;
  logic [PAT_W-1:0] patCount;
  logic [5:0] shiftCount;
  logic [4:0] capCount;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  logic_selftest_part #(.PAT_W(PAT_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .abortReq(abortReq),
    .patStop(patStop), .shiftDiv(shiftDiv), .expLo(expLo), .expHi(expHi),
    .faultMapUnrec(faultMapUnrec), .busy(busy), .done(done), .pass(pass),
    .faultRec(faultRec), .resetReq(resetReq), .aborted(aborted),
    .signature(signature), .patCount(patCount), .shiftCount(shiftCount),
    .capCount(capCount)
  );

  function automatic logic [63:0] adv(input logic [63:0] s);
    return {s[62:0], 1'b0} ^ (s[63] ? POLY : 64'h0);
  endfunction

  // Expected signature after a given number of steps (R5)
  function automatic logic [63:0] modelSig(input int steps);
    logic [63:0] s = SEED;
    logic [63:0] m = '0;
    for (int i = 0; i < steps; i++) begin
      if ((i % 75) >= 50) m = adv(m) ^ s;
      s = adv(s);
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runTo(input int p, input int d, output int cyc);
    @(negedge clk);
    patStop = PAT_W'(p); shiftDiv = DIV_W'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 sig", signature, 0); chk("R1 pat", patCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flags", {pass, faultRec, resetReq, aborted}, 0);
    chk("R1 counts", {shiftCount, capCount}, 0);
  endtask

  task automatic t_pass;
    int cyc;
    logic [63:0] e = modelSig(150);
    expLo = e[31:0]; expHi = e[63:32]; faultMapUnrec = 1'b0;
    runTo(2, 0, cyc);
    chk("R4 cycles P2 D0", cyc, 151);
    chk("R5 sig", signature, e);
    chk("R6 pass", pass, 1);
    chk("R7 no fault", {faultRec, resetReq}, 0);
    chk("R3 counts", {patCount, shiftCount, capCount}, {16'd2, 6'd50, 5'd25});
    repeat (20) @(negedge clk);
    chk("R8 hold", {done, pass, signature}, {1'b1, 1'b1, e});
  endtask

  task automatic t_div;
    int cyc;
    logic [63:0] e = modelSig(75);
    expLo = e[31:0]; expHi = e[63:32];
    runTo(1, 3, cyc);
    chk("R4 cycles P1 D3", cyc, 301);
    chk("R4 sig with divider", signature, e);
    chk("R6 pass div", pass, 1);
  endtask

  task automatic t_failHi;
    int cyc;
    logic [63:0] e = modelSig(75);
    expLo = e[31:0]; expHi = e[63:32] ^ 32'h20; faultMapUnrec = 1'b0;
    runTo(1, 0, cyc);
    chk("R6 hi bit mismatch", pass, 0);
    chk("R7 recoverable", {faultRec, resetReq}, 2'b10);
  endtask

  task automatic t_failLo;
    int cyc;
    logic [63:0] e = modelSig(75);
    expLo = e[31:0] ^ 32'h1; expHi = e[63:32]; faultMapUnrec = 1'b1;
    runTo(1, 0, cyc);
    chk("R6 lo bit mismatch", pass, 0);
    chk("R7 unrecoverable", {faultRec, resetReq}, 2'b01);
    faultMapUnrec = 1'b0;
  endtask

  task automatic t_busyIgnore;
    int cyc;
    logic [63:0] e = modelSig(75);
    expLo = e[31:0]; expHi = e[63:32];
    @(negedge clk);
    patStop = 16'd1; shiftDiv = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 clear done", done, 0);
    chk("R8 clear flags", {pass, faultRec, resetReq}, 0);
    chk("R2 clear sig", signature, 0);
    repeat (30) @(negedge clk);
    start = 1'b1; patStop = 16'd5; shiftDiv = 4'd7;
    @(negedge clk);
    start = 1'b0;
    cyc = 31;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R2 ignored start timing", cyc, 76);
    chk("R2 ignored patStop", patCount, 1);
    chk("R2 pass", pass, 1);
  endtask

  task automatic t_abort;
    logic [63:0] e = modelSig(60);
    expLo = '0; expHi = '0;
    @(negedge clk);
    patStop = 16'd3; shiftDiv = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chk("R9 flags", {busy, done, aborted, pass, faultRec, resetReq}, 6'b011000);
    chk("R9 partial sig", signature, e);
    chk("R9 counts", {patCount, shiftCount, capCount}, {16'd0, 6'd50, 5'd10});
    repeat (10) @(negedge clk);
    chk("R9 hold", {signature, capCount}, {e, 5'd10});
  endtask

  task automatic t_zero;
    int cyc;
    expLo = '0; expHi = '0;
    runTo(0, 5, cyc);
    chk("R10 cycles", cyc, 1);
    chk("R10 sig", signature, 0);
    chk("R10 pass", pass, 1);
    chk("R10 counts", {patCount, shiftCount, capCount}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks + 1, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_div();
    t_failHi();
    t_failLo();
    t_busyIgnore();
    t_abort();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule